// File: doc/BRIEF.md
# SPI Status Flag Unit

This block holds the status word of an SPI controller. The surrounding datapath sends it single-cycle event strobes: enable and disable commands, a write into the transmit holding register, a move of that data into the shifter, a load of the receive register from the shifter, a read of the receive register, the start of a transfer, the end of a shift, the end of the inter-transfer delay and a mode fault. It also receives the raw slave-select pin, which it synchronizes internally before looking for rising edges.

Software reads the flags through a small read port. When the read address matches the status offset, the port returns the packed 32-bit word combinationally in the same cycle. The sticky error and event bits are cleared at the clock edge that ends that read. Data flags are not cleared by status reads; they follow accesses to the data registers.

Top module: `spi_flag_keeper`

## Requirements
- R1: After synchronous reset the status word at offset 0x10 reads 0x00000000.
- R2: Bit positions: 0 receive-full, 1 holding-empty, 2 mode fault, 3 overrun, 8 slave-select rise, 9 transmit-empty, 10 underrun, 16 enabled. Every other bit reads 0.
- R3: The enabled bit goes to 1 one cycle after an enable strobe and to 0 one cycle after a disable strobe.
- R4: Holding-empty is 0 at reset and whenever the unit is disabled. An enable strobe sets it. While enabled, a holding write clears it and a holding-to-shifter move sets it. If both occur in the same cycle, the write wins.
- R5: Transmit-empty is cleared by a holding write. With no delay configured, it is set by shift-done while the holding register is empty. With a nonzero delay configured, it is set only when the delay-done strobe follows that shift-done. An enable strobe also sets it.
- R6: Receive-full is set by a receive-register load and cleared by a receive-register read.
- R7: Overrun is set when a receive load arrives while receive-full is 1 and no receive read happens in that cycle. It is cleared by a status read.
- R8: Underrun is set when, in slave mode with the unit enabled, a transfer starts while the holding register is empty. In master mode, or with the holding register loaded, a transfer start has no effect. A status read clears it.
- R9: Mode fault is set by a mode-fault strobe and cleared by a status read.
- R10: A low-to-high change of the slave-select pin sets the rise bit once it has passed a two-stage synchronizer, so it is visible three clock edges after the pin changes. A falling edge has no effect. A status read clears the bit.
- R11: When a set event and a clearing status read fall in the same cycle, the bit ends up set. The read returns the value held before that cycle's update.
- R12: A read at any address other than 0x10 returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_cmd | input | 1 | Enable command strobe |
| dis_cmd | input | 1 | Disable command strobe |
| slave_mode | input | 1 | 1 when the controller runs as slave |
| dly_nonzero | input | 1 | 1 when an inter-transfer delay is configured |
| thr_wr | input | 1 | Write into the transmit holding register |
| thr_load | input | 1 | Holding register moved into the shifter |
| rx_load | input | 1 | Shifter loaded into the receive register |
| rx_read | input | 1 | Receive register read |
| xfer_start | input | 1 | A transfer begins |
| shift_done | input | 1 | Shifter became idle |
| dly_done | input | 1 | Inter-transfer delay finished |
| mode_fault_evt | input | 1 | Mode fault detected |
| ss_in | input | 1 | Asynchronous slave-select pin |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Read data (status word on address match, else 0) |

## Verification
The assertions check the following on every cycle: that the receive and mode-fault sets follow their strobes, that overrun follows a second unread load, that a holding write drops transmit-empty, that holding-empty stays low while the unit is disabled, that a status read clears mode fault, and that reserved bits and unmatched addresses read zero. Some behaviours can only be shown by the bench's scenarios. These are the ordered sequences: the delay-gated rise of transmit-empty, the slave-only and holding-empty conditions for underrun, the synchronizer latency and edge polarity of the slave-select bit, and the collision of a set event with a clearing read.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned B_RXFULL = 0;
    localparam int unsigned B_THRMT  = 1;
    localparam int unsigned B_MODF   = 2;
    localparam int unsigned B_OVR    = 3;
    localparam int unsigned B_SSRISE = 8;
    localparam int unsigned B_TXMT   = 9;
    localparam int unsigned B_UNDR   = 10;
    localparam int unsigned B_ENA    = 16;

    localparam logic [WORD_W-1:0] USED_MASK =
        (32'd1 << B_RXFULL) | (32'd1 << B_THRMT) | (32'd1 << B_MODF) |
        (32'd1 << B_OVR) | (32'd1 << B_SSRISE) | (32'd1 << B_TXMT) |
        (32'd1 << B_UNDR) | (32'd1 << B_ENA);

    typedef struct packed {
        logic enabled;
        logic ss_rise;
        logic tx_empty;
        logic underrun;
        logic overrun;
        logic mode_fault;
        logic thr_empty;
        logic rx_full;
    } flags_t;

    function automatic logic [WORD_W-1:0] pack_status(input flags_t f);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[B_RXFULL] = f.rx_full;
        w[B_THRMT]  = f.thr_empty;
        w[B_MODF]   = f.mode_fault;
        w[B_OVR]    = f.overrun;
        w[B_SSRISE] = f.ss_rise;
        w[B_TXMT]   = f.tx_empty;
        w[B_UNDR]   = f.underrun;
        w[B_ENA]    = f.enabled;
        return w;
    endfunction

endpackage

// File: rtl/spi_ss_edge.sv
module spi_ss_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ss_in,
    input  logic status_clr,
    output logic ss_rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise_now;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= ss_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[STAGES-2:0], ss_in};
            end
        end
    endgenerate

    assign rise_now = sync_q[STAGES-1] & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            ss_rise <= 1'b0;
        end else begin
            prev_q <= sync_q[STAGES-1];
            if (rise_now)        ss_rise <= 1'b1;
            else if (status_clr) ss_rise <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_tx_flags.sv
module spi_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic slave_mode,
    input  logic dly_nonzero,
    input  logic thr_wr,
    input  logic thr_load,
    input  logic shift_done,
    input  logic dly_done,
    input  logic xfer_start,
    input  logic status_clr,
    output logic enabled,
    output logic thr_empty,
    output logic tx_empty,
    output logic underrun
);
    logic dly_wait;
    logic hold_free;
    logic idle_reached;

    assign hold_free    = thr_empty & ~thr_load;
    assign idle_reached = dly_nonzero ? (dly_wait & dly_done) : shift_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled   <= 1'b0;
            thr_empty <= 1'b0;
            tx_empty  <= 1'b0;
            underrun  <= 1'b0;
            dly_wait  <= 1'b0;
        end else begin
            if (dis_cmd)     enabled <= 1'b0;
            else if (en_cmd) enabled <= 1'b1;

            if (dis_cmd)       thr_empty <= 1'b0;
            else if (en_cmd)   thr_empty <= 1'b1;
            else if (enabled) begin
                if (thr_wr)        thr_empty <= 1'b0;
                else if (thr_load) thr_empty <= 1'b1;
            end

            if (thr_wr || thr_load)            dly_wait <= 1'b0;
            else if (shift_done && dly_nonzero) dly_wait <= 1'b1;
            else if (dly_done)                 dly_wait <= 1'b0;

            if (thr_wr)                         tx_empty <= 1'b0;
            else if (en_cmd)                    tx_empty <= 1'b1;
            else if (hold_free && idle_reached) tx_empty <= 1'b1;

            if (enabled && slave_mode && xfer_start && thr_empty) underrun <= 1'b1;
            else if (status_clr)                                  underrun <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags (
    input  logic clk,
    input  logic rst,
    input  logic rx_load,
    input  logic rx_read,
    input  logic mode_fault_evt,
    input  logic status_clr,
    output logic rx_full,
    output logic overrun,
    output logic mode_fault
);
    logic second_load;

    assign second_load = rx_load & rx_full & ~rx_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full    <= 1'b0;
            overrun    <= 1'b0;
            mode_fault <= 1'b0;
        end else begin
            if (rx_load)      rx_full <= 1'b1;
            else if (rx_read) rx_full <= 1'b0;

            if (second_load)     overrun <= 1'b1;
            else if (status_clr) overrun <= 1'b0;

            if (mode_fault_evt)  mode_fault <= 1'b1;
            else if (status_clr) mode_fault <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_flag_keeper.sv
module spi_flag_keeper
    import spi_flag_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned STATUS_OFS = 'h10,
    parameter int unsigned SS_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    input  logic              slave_mode,
    input  logic              dly_nonzero,
    input  logic              thr_wr,
    input  logic              thr_load,
    input  logic              rx_load,
    input  logic              rx_read,
    input  logic              xfer_start,
    input  logic              shift_done,
    input  logic              dly_done,
    input  logic              mode_fault_evt,
    input  logic              ss_in,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] OFS = STATUS_OFS[ADDR_W-1:0];

    flags_t flags;
    logic   status_clr;

    assign status_clr = rd_en && (rd_addr == OFS);

    spi_tx_flags i_tx (
        .clk        (clk),
        .rst        (rst),
        .en_cmd     (en_cmd),
        .dis_cmd    (dis_cmd),
        .slave_mode (slave_mode),
        .dly_nonzero(dly_nonzero),
        .thr_wr     (thr_wr),
        .thr_load   (thr_load),
        .shift_done (shift_done),
        .dly_done   (dly_done),
        .xfer_start (xfer_start),
        .status_clr (status_clr),
        .enabled    (flags.enabled),
        .thr_empty  (flags.thr_empty),
        .tx_empty   (flags.tx_empty),
        .underrun   (flags.underrun)
    );

    spi_rx_flags i_rx (
        .clk           (clk),
        .rst           (rst),
        .rx_load       (rx_load),
        .rx_read       (rx_read),
        .mode_fault_evt(mode_fault_evt),
        .status_clr    (status_clr),
        .rx_full       (flags.rx_full),
        .overrun       (flags.overrun),
        .mode_fault    (flags.mode_fault)
    );

    spi_ss_edge #(.STAGES(SS_STAGES)) i_ss (
        .clk       (clk),
        .rst       (rst),
        .ss_in     (ss_in),
        .status_clr(status_clr),
        .ss_rise   (flags.ss_rise)
    );

    assign rd_data = status_clr ? pack_status(flags) : '0;
endmodule

// File: rtl/spi_flag_keeper_chk.sv
module spi_flag_keeper_chk
    import spi_flag_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned STATUS_OFS = 'h10
) (
    input logic              clk,
    input logic              rst,
    input logic              thr_wr,
    input logic              rx_load,
    input logic              rx_read,
    input logic              mode_fault_evt,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input flags_t            flags
);
    logic hit;
    assign hit = rd_en && (rd_addr == STATUS_OFS[ADDR_W-1:0]);

    // R6
    rx_full_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx_load |=> flags.rx_full);

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_load && flags.rx_full && !rx_read) |=> flags.overrun);

    // R4
    thr_idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        !flags.enabled |-> !flags.thr_empty);

    // R5
    tx_empty_drop_chk: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !flags.tx_empty);

    // R9
    modf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !mode_fault_evt) |=> !flags.mode_fault);

    // R11
    modf_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        mode_fault_evt |=> flags.mode_fault);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~USED_MASK) == '0);

    // R12
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |-> rd_data == '0);
endmodule

bind spi_flag_keeper spi_flag_keeper_chk #(
    .ADDR_W    (ADDR_W),
    .STATUS_OFS(STATUS_OFS)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .thr_wr        (thr_wr),
    .rx_load       (rx_load),
    .rx_read       (rx_read),
    .mode_fault_evt(mode_fault_evt),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .flags         (flags)
);

// File: tb/test_spi_flag_keeper.sv
`timescale 1ns/1ps
module test_spi_flag_keeper;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_cmd = 0, dis_cmd = 0, slave_mode = 0, dly_nonzero = 0;
    logic thr_wr = 0, thr_load = 0, rx_load = 0, rx_read = 0;
    logic xfer_start = 0, shift_done = 0, dly_done = 0, mode_fault_evt = 0;
    logic ss_in = 1'b1;
    logic rd_en = 0;
    logic [7:0]  rd_addr = 8'h00;
    logic [31:0] rd_data;
    logic [31:0] v;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_flag_keeper i_spi_flag_keeper (
        .clk(clk), .rst(rst), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .slave_mode(slave_mode), .dly_nonzero(dly_nonzero), .thr_wr(thr_wr),
        .thr_load(thr_load), .rx_load(rx_load), .rx_read(rx_read),
        .xfer_start(xfer_start), .shift_done(shift_done), .dly_done(dly_done),
        .mode_fault_evt(mode_fault_evt), .ss_in(ss_in), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] r);
        rd_en = 1; rd_addr = a;
        #1 r = rd_data;
        step();
        rd_en = 0;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic t_reset();
        rd(8'h10, v); chk("R1 reset word", v, 32'h0);
    endtask

    task automatic t_enable();
        en_cmd = 1; step(); en_cmd = 0;
        rd(8'h10, v); chk("R3 R4 enabled word", v, 32'h0001_0202);
        dis_cmd = 1; step(); dis_cmd = 0;
        rd(8'h10, v); chk("R3 R4 disabled word", v, 32'h0000_0200);
        thr_load = 1; step(); thr_load = 0;
        rd(8'h10, v); chk("R4 move while disabled", v & 32'h2, 32'h0);
        en_cmd = 1; step(); en_cmd = 0;
        rd(8'h10, v); chk("R2 R3 re-enabled", v, 32'h0001_0202);
    endtask

    task automatic t_tx();
        thr_wr = 1; step(); thr_wr = 0;
        rd(8'h10, v); chk("R4 R5 after write", v & 32'h202, 32'h0);
        thr_load = 1; step(); thr_load = 0;
        rd(8'h10, v); chk("R4 after move", v & 32'h202, 32'h002);
        shift_done = 1; step(); shift_done = 0;
        rd(8'h10, v); chk("R5 idle no delay", v & 32'h202, 32'h202);
        dly_nonzero = 1;
        thr_wr = 1; step(); thr_wr = 0;
        thr_load = 1; step(); thr_load = 0;
        shift_done = 1; step(); shift_done = 0;
        rd(8'h10, v); chk("R5 waiting delay", v & 32'h202, 32'h002);
        dly_done = 1; step(); dly_done = 0;
        rd(8'h10, v); chk("R5 delay done", v & 32'h202, 32'h202);
        dly_nonzero = 0;
    endtask

    task automatic t_rx();
        rx_load = 1; step(); rx_load = 0;
        rd(8'h10, v); chk("R6 load sets full", v & 32'h9, 32'h1);
        rx_read = 1; step(); rx_read = 0;
        rd(8'h10, v); chk("R6 read clears full", v & 32'h9, 32'h0);
        rx_load = 1; step(); step(); rx_load = 0;
        rd(8'h10, v); chk("R7 double load", v & 32'h9, 32'h9);
        rd(8'h10, v); chk("R7 cleared by status read", v & 32'h9, 32'h1);
        rx_load = 1; rx_read = 1; step(); rx_load = 0; rx_read = 0;
        rd(8'h10, v); chk("R7 load with read no overrun", v & 32'h9, 32'h1);
        rx_read = 1; step(); rx_read = 0;
    endtask

    task automatic t_underrun();
        slave_mode = 1;
        xfer_start = 1; step(); xfer_start = 0;
        rd(8'h10, v); chk("R8 slave empty start", v & 32'h400, 32'h400);
        rd(8'h10, v); chk("R8 cleared by read", v & 32'h400, 32'h0);
        slave_mode = 0;
        xfer_start = 1; step(); xfer_start = 0;
        rd(8'h10, v); chk("R8 master no effect", v & 32'h400, 32'h0);
        slave_mode = 1;
        thr_wr = 1; step(); thr_wr = 0;
        xfer_start = 1; step(); xfer_start = 0;
        rd(8'h10, v); chk("R8 loaded no effect", v & 32'h400, 32'h0);
        thr_load = 1; step(); thr_load = 0;
        slave_mode = 0;
    endtask

    task automatic t_modf();
        mode_fault_evt = 1; step(); mode_fault_evt = 0;
        rd(8'h10, v); chk("R9 fault set", v & 32'h4, 32'h4);
        rd(8'h10, v); chk("R9 fault cleared", v & 32'h4, 32'h0);
    endtask

    task automatic t_ss();
        ss_in = 0; repeat (4) step();
        rd(8'h10, v); chk("R10 falling no effect", v & 32'h100, 32'h0);
        ss_in = 1; step(); step();
        rd(8'h10, v); chk("R10 not yet visible", v & 32'h100, 32'h0);
        step();
        rd(8'h10, v); chk("R10 rise seen", v & 32'h100, 32'h100);
        rd(8'h10, v); chk("R10 cleared", v & 32'h100, 32'h0);
    endtask

    task automatic t_collide();
        mode_fault_evt = 1;
        rd(8'h10, v); mode_fault_evt = 0;
        chk("R11 read returns old", v & 32'h4, 32'h0);
        rd(8'h10, v); chk("R11 set survived", v & 32'h4, 32'h4);
        rd(8'h10, v); chk("R11 then cleared", v & 32'h4, 32'h0);
    endtask

    task automatic t_addr();
        mode_fault_evt = 1; step(); mode_fault_evt = 0;
        rd(8'h14, v); chk("R12 miss reads zero", v, 32'h0);
        rd(8'h10, v); chk("R12 miss did not clear", v & 32'h4, 32'h4);
    endtask

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        t_reset();
        t_enable();
        t_tx();
        t_rx();
        t_underrun();
        t_modf();
        t_ss();
        t_collide();
        t_addr();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule